// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block decides, for every memory access a processor core presents, whether the access may proceed or must raise a memory-management fault. Software describes up to eight address windows. Each window has an inclusive lower and upper address at 32-byte granularity, an access-permission code, an execute-never flag and an index into a shared table of memory attribute bytes. The unit reports whether the access is allowed, which window matched, and the attribute byte of that window.

Three control bits shape the decision. One bit turns checking on. A second bit keeps checking active while the core runs a hard-fault, non-maskable-interrupt or fault-masked handler; when this bit is clear, such accesses pass unchecked. A third bit lets privileged accesses that match no window fall through to a background map, which ranks below every window. Software reaches all configuration through a small word-wide register port. A select register picks the window that the lower-bound and upper-bound registers address.

The verdict for an access that is presented with `accValid` high appears one clock later on the `resp*` outputs. The decision always uses the configuration that was in force before any register write made in the same cycle.

Top module: `mpu_unit`

## Requirements
- R1: After reset the control bits, the select register, every region register and every attribute byte read as zero, and no response is flagged valid until an access has been presented.
- R2: With control bit 0 (unit on) clear, every access is allowed and reports no hit, whatever control bit 2 holds and whatever the regions contain.
- R3: With the unit on and control bit 1 clear, an access flagged `accHandler` is allowed with no hit reported. With control bit 1 set, the same access is checked normally.
- R4: A region whose upper-bound bit 0 (enable) is set matches address A when A[31:5] >= lower[31:5] and A[31:5] <= upper[31:5]. Both ends are inclusive, so A = upper[31:5]·32 + 31 matches and the next byte does not.
- R5: When several enabled regions match, the one with the highest number is reported in `respRegion` and supplies the permissions. A region whose enable bit is clear never matches.
- R6: With the unit on and no region matching, the access faults if control bit 2 is clear. If control bit 2 is set, a privileged access is allowed and an unprivileged one faults. In both cases `respHit` is 0 and `respRegion` and `respAttr` are 0.
- R7: Lower-bound bits [4:3] encode permission as 00 read-write privileged only, 01 read-write any level, 10 read-only privileged only, 11 read-only any level. A write (`accType` 1) to a read-only region faults, an unprivileged access to a privileged-only region faults, and other accesses are allowed. Instruction fetch (`accType` 2) counts as a read.
- R8: An instruction fetch from a region whose lower-bound bit 0 (execute-never) is set faults, and a data read of the same region is allowed.
- R9: Upper-bound bits [3:1] index the attribute table. Register 4 holds bytes 0..3 and register 5 holds bytes 4..7, byte k at bits 8·(k mod 4)+7 : 8·(k mod 4). `respAttr` carries the byte of the winning region, even when the access faults.
- R10: The register addresses are 0 control (bits 2:0), 1 select (bits 2:0), 2 lower bound of the selected region, 3 upper bound of the selected region, 4 and 5 attribute table. Reads return the stored values, and upper-bound bit 4 always reads 0.
- R11: `respValid` and the other response outputs follow `accValid` by exactly one clock. The verdict uses the configuration in force before a register write made in the same cycle. While `respValid` is 0, all other response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | 32 | Access byte address |
| accPriv | input | 1 | 1 for a privileged access |
| accType | input | 2 | 0 read, 1 write, 2 instruction fetch |
| accHandler | input | 1 | Access made in a hard-fault, NMI or fault-masked handler |
| respValid | output | 1 | Verdict valid (one cycle after `accValid`) |
| respAllow | output | 1 | Access permitted |
| respFault | output | 1 | Memory-management fault |
| respHit | output | 1 | An enabled region matched |
| respRegion | output | 3 | Number of the winning region |
| respAttr | output | 8 | Attribute byte of the winning region |

## Verification
A configuration write and an access evaluation can land in the same clock. The write may change the very control bit, bound or attribute byte that decides that access. The bench provokes this by driving a write and an access together, for example switching the unit off while presenting an access that would fault, and retargeting an attribute index under a live access. Its reference model computes each verdict from its copy of the registers before it applies that cycle's write. The next access then shows the new setting.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int WORD_W     = 32;
  localparam int ALIGN_BITS = 5;
  localparam int ATTR_N     = 8;
  localparam int ATTR_IDX_W = $clog2(ATTR_N);

  // control bit positions
  localparam int CTRL_EN = 0;
  localparam int CTRL_HF = 1;
  localparam int CTRL_BG = 2;

  // lower-bound field positions
  localparam int LOW_XN     = 0;
  localparam int LOW_AP_LSB = 3;

  // upper-bound field positions
  localparam int UP_EN       = 0;
  localparam int UP_ATTR_LSB = 1;
  localparam logic [WORD_W-1:0] UP_KEEP_MASK = 32'hFFFF_FFEF;

  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_SEL     = 3'd1,
    REG_LOW     = 3'd2,
    REG_UP      = 3'd3,
    REG_ATTR_LO = 3'd4,
    REG_ATTR_HI = 3'd5
  } regAddrE;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accTypeE;

  typedef struct packed {
    logic              wrCtrl;
    logic              wrSel;
    logic              wrLow;
    logic              wrUp;
    logic              wrAttrLo;
    logic              wrAttrHi;
    logic [WORD_W-1:0] data;
    logic              bypassAll;
    logic              useBackground;
  } cfgStrobeT;

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
  parameter int ADDR_W = 32,
  parameter int ALIGN  = 5
) (
  input  logic [ADDR_W-1:0] lowReg,
  input  logic [ADDR_W-1:0] upReg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enable,
  output logic              hit
);
  localparam int HI_W = ADDR_W - ALIGN;

  logic [HI_W-1:0] addrBlk;
  logic [HI_W-1:0] lowBlk;
  logic [HI_W-1:0] upBlk;

  assign addrBlk = addr[ADDR_W-1:ALIGN];
  assign lowBlk  = lowReg[ADDR_W-1:ALIGN];
  assign upBlk   = upReg[ADDR_W-1:ALIGN];

  // low field bits are treated as zero / ones, so compare block numbers only
  assign hit = enable && (addrBlk >= lowBlk) && (addrBlk <= upBlk);

  // unused field bits of the bound registers
  logic unusedBits;
  assign unusedBits = ^{lowReg[ALIGN-1:0], upReg[ALIGN-1:0], addr[ALIGN-1:0]};
endmodule

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
  import mpu_pkg::*;
(
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [2:0]        ctrlQ,
  input  logic              accHandler,
  output cfgStrobeT         strb
);

  always_comb begin
    strb      = '0;
    strb.data = regWdata;
    if (regWrEn) begin
      case (regAddrE'(regAddr))
        REG_CTRL:    strb.wrCtrl   = 1'b1;
        REG_SEL:     strb.wrSel    = 1'b1;
        REG_LOW:     strb.wrLow    = 1'b1;
        REG_UP:      strb.wrUp     = 1'b1;
        REG_ATTR_LO: strb.wrAttrLo = 1'b1;
        REG_ATTR_HI: strb.wrAttrHi = 1'b1;
        default:     ;
      endcase
    end
    // unit off, or handler context while the handler-keep bit is clear
    strb.bypassAll     = !ctrlQ[CTRL_EN] || (accHandler && !ctrlQ[CTRL_HF]);
    strb.useBackground = ctrlQ[CTRL_BG];
  end

endmodule

// File: rtl/mpu_datapath.sv
module mpu_datapath
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int REGION_W   = $clog2(NUM_REGIONS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobeT           strb,
  input  logic [2:0]          regAddr,
  output logic [WORD_W-1:0]   regRdata,
  output logic [2:0]          ctrlQ,
  input  logic                accValid,
  input  logic [WORD_W-1:0]   accAddr,
  input  logic                accPriv,
  input  logic [1:0]          accType,
  output logic                respValid,
  output logic                respAllow,
  output logic                respFault,
  output logic                respHit,
  output logic [REGION_W-1:0] respRegion,
  output logic [7:0]          respAttr
);

  logic [REGION_W-1:0] selQ;
  logic [WORD_W-1:0]   lowQ [NUM_REGIONS];
  logic [WORD_W-1:0]   upQ  [NUM_REGIONS];
  logic [7:0]          attrQ[ATTR_N];

  // ---------------- configuration storage ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      selQ  <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        lowQ[i] <= '0;
        upQ[i]  <= '0;
      end
      for (int k = 0; k < ATTR_N; k++) attrQ[k] <= '0;
    end else begin
      if (strb.wrCtrl) ctrlQ <= strb.data[2:0];
      if (strb.wrSel)  selQ  <= strb.data[REGION_W-1:0];
      if (strb.wrLow)  lowQ[selQ] <= strb.data;
      if (strb.wrUp)   upQ[selQ]  <= strb.data & UP_KEEP_MASK;
      if (strb.wrAttrLo)
        for (int k = 0; k < 4; k++) attrQ[k] <= strb.data[8*k +: 8];
      if (strb.wrAttrHi)
        for (int k = 0; k < 4; k++) attrQ[4+k] <= strb.data[8*k +: 8];
    end
  end

  // R10: the decoder never raises two write strobes together
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrSel, strb.wrLow, strb.wrUp, strb.wrAttrLo, strb.wrAttrHi}));

  // ---------------- read-back ----------------
  always_comb begin
    case (regAddrE'(regAddr))
      REG_CTRL:    regRdata = {{(WORD_W-3){1'b0}}, ctrlQ};
      REG_SEL:     regRdata = WORD_W'(selQ);
      REG_LOW:     regRdata = lowQ[selQ];
      REG_UP:      regRdata = upQ[selQ];
      REG_ATTR_LO: regRdata = {attrQ[3], attrQ[2], attrQ[1], attrQ[0]};
      REG_ATTR_HI: regRdata = {attrQ[7], attrQ[6], attrQ[5], attrQ[4]};
      default:     regRdata = '0;
    endcase
  end

  // ---------------- parallel window compare ----------------
  logic [NUM_REGIONS-1:0] hitVec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    mpu_region_match #(
      .ADDR_W (WORD_W),
      .ALIGN  (ALIGN_BITS)
    ) i_match (
      .lowReg (lowQ[g]),
      .upReg  (upQ[g]),
      .addr   (accAddr),
      .enable (upQ[g][UP_EN]),
      .hit    (hitVec[g])
    );
  end

  // ---------------- priority: highest number wins ----------------
  logic                anyHit;
  logic [REGION_W-1:0] winIdx;

  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = REGION_W'(i);
      end
    end
  end

  // ---------------- permission check ----------------
  logic [WORD_W-1:0]     winLow;
  logic [1:0]            winAp;
  logic                  winXn;
  logic [ATTR_IDX_W-1:0] winAttrIdx;
  logic                  permFault;

  assign winLow     = lowQ[winIdx];
  assign winAp      = winLow[LOW_AP_LSB +: 2];
  assign winXn      = winLow[LOW_XN];
  assign winAttrIdx = upQ[winIdx][UP_ATTR_LSB +: ATTR_IDX_W];

  always_comb begin
    permFault = 1'b0;
    if (accTypeE'(accType) == ACC_WRITE && winAp[1]) permFault = 1'b1;
    if (!accPriv && !winAp[0])                       permFault = 1'b1;
    if (accTypeE'(accType) == ACC_FETCH && winXn)    permFault = 1'b1;
  end

  logic                decAllow;
  logic                decHit;
  logic [REGION_W-1:0] decIdx;
  logic [7:0]          decAttr;

  always_comb begin
    decAllow = 1'b1;
    decHit   = 1'b0;
    decIdx   = '0;
    decAttr  = '0;
    if (!strb.bypassAll) begin
      if (anyHit) begin
        decAllow = !permFault;
        decHit   = 1'b1;
        decIdx   = winIdx;
        decAttr  = attrQ[winAttrIdx];
      end else begin
        decAllow = strb.useBackground && accPriv;
      end
    end
  end

  // ---------------- response register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respAllow  <= 1'b0;
      respFault  <= 1'b0;
      respHit    <= 1'b0;
      respRegion <= '0;
      respAttr   <= '0;
    end else begin
      respValid  <= accValid;
      respAllow  <= accValid && decAllow;
      respFault  <= accValid && !decAllow;
      respHit    <= accValid && decHit;
      respRegion <= accValid ? decIdx  : '0;
      respAttr   <= accValid ? decAttr : '0;
    end
  end

  // R2 and R3: a bypassed access is allowed and reports no window
  a_r3_bypass_allows: assert property (@(posedge clk) disable iff (!rstN)
    accValid && strb.bypassAll |=> respAllow && !respHit);

  // R6: no window, no background map -> fault
  a_r6_no_window_faults: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !strb.bypassAll && !strb.useBackground && !anyHit |=> respFault && !respHit);

  // R5: a matching enabled window is always reported
  a_r5_hit_reported: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !strb.bypassAll && anyHit |=> respHit);

  // R8: fetch from an execute-never window faults
  a_r8_xn_fetch: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !strb.bypassAll && anyHit && winXn && accTypeE'(accType) == ACC_FETCH
    |=> respFault);

  // R7: writes into a read-only window fault
  a_r7_ro_write: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !strb.bypassAll && anyHit && winAp[1] && accTypeE'(accType) == ACC_WRITE
    |=> respFault);

  // R11: nothing but zeros while no verdict is flagged
  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !respAllow && !respFault && !respHit && respAttr == 8'd0);

endmodule

// File: rtl/mpu_unit.sv
module mpu_unit
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int REGION_W   = $clog2(NUM_REGIONS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic                accValid,
  input  logic [31:0]         accAddr,
  input  logic                accPriv,
  input  logic [1:0]          accType,
  input  logic                accHandler,
  output logic                respValid,
  output logic                respAllow,
  output logic                respFault,
  output logic                respHit,
  output logic [REGION_W-1:0] respRegion,
  output logic [7:0]          respAttr
);

  cfgStrobeT  strb;
  logic [2:0] ctrlQ;

  mpu_ctrl i_ctrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .ctrlQ      (ctrlQ),
    .accHandler (accHandler),
    .strb       (strb)
  );

  mpu_datapath #(
    .NUM_REGIONS (NUM_REGIONS)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regAddr    (regAddr),
    .regRdata   (regRdata),
    .ctrlQ      (ctrlQ),
    .accValid   (accValid),
    .accAddr    (accAddr),
    .accPriv    (accPriv),
    .accType    (accType),
    .respValid  (respValid),
    .respAllow  (respAllow),
    .respFault  (respFault),
    .respHit    (respHit),
    .respRegion (respRegion),
    .respAttr   (respAttr)
  );

endmodule

// File: tb/test_mpu_unit.sv
`timescale 1ns/1ps
module test_mpu_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accPriv = 1'b0;
  logic [1:0]  accType = '0;
  logic        accHandler = 1'b0;
  logic        respValid, respAllow, respFault, respHit;
  logic [2:0]  respRegion;
  logic [7:0]  respAttr;

  always #2 clk = ~clk;  // 250 MHz

  mpu_unit i_mpu_unit (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .accValid(accValid), .accAddr(accAddr), .accPriv(accPriv), .accType(accType),
    .accHandler(accHandler),
    .respValid(respValid), .respAllow(respAllow), .respFault(respFault),
    .respHit(respHit), .respRegion(respRegion), .respAttr(respAttr)
  );

  int  nChk = 0;
  int  nBad = 0;
  bit  finished = 0;

  // behavioural model state
  logic [31:0] mLow [8];
  logic [31:0] mUp  [8];
  logic [7:0]  mAttr[8];
  logic [2:0]  mCtrl;
  logic [2:0]  mSel;

  logic [14:0] qExp[$];
  string       qTag[$];

  // next-cycle stimulus
  bit          nWr, nAcc, nRd, nPriv, nHand;
  logic [2:0]  nAddr;
  logic [31:0] nData, nAccAddr;
  logic [1:0]  nType;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, mCtrl};
      3'd1: return {29'd0, mSel};
      3'd2: return mLow[mSel];
      3'd3: return mUp[mSel];
      3'd4: return {mAttr[3], mAttr[2], mAttr[1], mAttr[0]};
      3'd5: return {mAttr[7], mAttr[6], mAttr[5], mAttr[4]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic void modelWrite(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: mCtrl = d[2:0];
      3'd1: mSel = d[2:0];
      3'd2: mLow[mSel] = d;
      3'd3: mUp[mSel] = d & 32'hFFFF_FFEF;
      3'd4: for (int k = 0; k < 4; k++) mAttr[k] = d[8*k +: 8];
      3'd5: for (int k = 0; k < 4; k++) mAttr[4+k] = d[8*k +: 8];
      default: ;
    endcase
  endfunction

  // verdict packed as {valid, allow, fault, hit, region[2:0], attr[7:0]}
  function automatic logic [14:0] modelVerdict(input bit v, input logic [31:0] a,
                                               input bit p, input logic [1:0] t, input bit h);
    bit         allow = 1;
    bit         hit = 0;
    int         idx = 0;
    logic [7:0] attr = 8'd0;
    if (!v) return 15'd0;
    if (mCtrl[0] && !(h && !mCtrl[1])) begin
      for (int r = 7; r >= 0; r--) begin
        if (mUp[r][0] && (a >> 5) >= (mLow[r] >> 5) && (a >> 5) <= (mUp[r] >> 5)) begin
          hit = 1;
          idx = r;
          break;
        end
      end
      if (hit) begin
        logic [1:0] ap;
        ap    = mLow[idx][4:3];
        allow = !((t == 2'd1 && ap[1]) || (!p && !ap[0]) || (t == 2'd2 && mLow[idx][0]));
        attr  = mAttr[mUp[idx][3:1]];
      end else begin
        allow = mCtrl[2] && p;
      end
    end
    return {1'b1, allow, !allow, hit, 3'(idx), attr};
  endfunction

  task automatic step(input string tag);
    logic [14:0] got, e;
    string tg;
    @(negedge clk);
    got = {respValid, respAllow, respFault, respHit, respRegion, respAttr};
    if (qExp.size() > 0) begin
      e  = qExp.pop_front();
      tg = qTag.pop_front();
      chk(got === e, tg, "verdict {v,al,fl,hit,reg,attr}", 32'(got), 32'(e));
    end
    regWrEn = nWr; regAddr = nAddr; regWdata = nData;
    accValid = nAcc; accAddr = nAccAddr; accPriv = nPriv; accType = nType; accHandler = nHand;
    #0.5;
    if (nRd) chk(regRdata === modelRead(nAddr), tag, "readback", regRdata, modelRead(nAddr));
    qExp.push_back(modelVerdict(nAcc, nAccAddr, nPriv, nType, nHand));
    qTag.push_back(tag);
    if (nWr) modelWrite(nAddr, nData);
    nWr = 0; nAcc = 0; nRd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    nWr = 1; nAddr = a; nData = d;
    step(tag);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    nRd = 1; nAddr = a;
    step(tag);
  endtask

  task automatic acc(input logic [31:0] a, input bit p, input logic [1:0] t, input bit h,
                     input string tag);
    nAcc = 1; nAccAddr = a; nPriv = p; nType = t; nHand = h;
    step(tag);
  endtask

  task automatic region(input int r, input logic [31:0] lo, input logic [31:0] up,
                        input string tag);
    wr(3'd1, 32'(r), tag);
    wr(3'd2, lo, tag);
    wr(3'd3, up, tag);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mLow[i] = 0; mUp[i] = 0; mAttr[i] = 0; end
    mCtrl = 0; mSel = 0;
    nWr = 0; nAcc = 0; nRd = 0; nPriv = 0; nHand = 0;
    nAddr = 0; nData = 0; nAccAddr = 0; nType = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(respValid === 1'b0, "R1", "respValid after reset", 32'(respValid), 0);
    for (int a = 0; a < 6; a++) rd(3'(a), "R1");
    for (int r = 0; r < 8; r++) begin wr(3'd1, 32'(r), "R1"); rd(3'd3, "R1"); end

    // R2: unit off, background bit set, a region that would fault
    wr(3'd0, 32'h4, "R2");
    region(6, 32'h0000_0019, 32'h0000_0FE1, "R2");
    acc(32'h0000_0100, 0, 2'd2, 0, "R2");
    acc(32'h0000_0100, 0, 2'd1, 0, "R2");
    acc(32'h9000_0000, 0, 2'd0, 0, "R2");
    region(6, 32'h0, 32'h0, "R2");

    // configure attribute table and regions
    wr(3'd4, 32'h77AA_0044, "R9");
    wr(3'd5, 32'h1122_3344, "R9");
    rd(3'd4, "R10"); rd(3'd5, "R10");
    region(0, 32'h0000_0018, 32'h007F_FFE1, "R10");          // AP 11, attr 0
    region(1, 32'h4001_0009, 32'h4001_3FE3, "R10");          // AP 01, XN, attr 1
    region(2, 32'h2000_0000, 32'h2000_0FE5, "R10");          // AP 00, attr 2
    region(3, 32'h2000_1010, 32'h2000_1FF5, "R10");          // AP 10, attr 2; bit4 dropped
    rd(3'd3, "R10"); rd(3'd2, "R10"); rd(3'd1, "R10");
    wr(3'd0, 32'h1, "R6");
    rd(3'd0, "R10");

    // R4: inclusive edges
    acc(32'h007F_FFFF, 0, 2'd0, 0, "R4");
    acc(32'h0080_0000, 1, 2'd0, 0, "R4");
    acc(32'h4001_0000, 1, 2'd0, 0, "R4");
    acc(32'h4001_3FFF, 1, 2'd0, 0, "R4");
    acc(32'h4000_FFFF, 1, 2'd0, 0, "R4");
    acc(32'h4001_4000, 1, 2'd0, 0, "R4");

    // R7: permission codes
    acc(32'h0000_1000, 1, 2'd1, 0, "R7");
    acc(32'h0000_1000, 0, 2'd0, 0, "R7");
    acc(32'h2000_0040, 0, 2'd0, 0, "R7");
    acc(32'h2000_0040, 1, 2'd1, 0, "R7");
    acc(32'h2000_1040, 1, 2'd1, 0, "R7");
    acc(32'h2000_1040, 1, 2'd0, 0, "R7");
    acc(32'h2000_1040, 0, 2'd0, 0, "R7");
    acc(32'h4001_0100, 0, 2'd1, 0, "R7");

    // R8: execute-never
    acc(32'h4001_0100, 1, 2'd2, 0, "R8");
    acc(32'h4001_0100, 0, 2'd0, 0, "R8");
    acc(32'h0000_0200, 0, 2'd2, 0, "R8");

    // R5: overlapping windows, highest number wins; disabled never matches
    region(5, 32'h2000_0008, 32'h2000_0FEF, "R5");           // AP 01, attr 7
    acc(32'h2000_0040, 0, 2'd0, 0, "R5");
    acc(32'h2000_0FFF, 0, 2'd1, 0, "R5");
    wr(3'd3, 32'h2000_0FEE, "R5");                           // disable region 5
    acc(32'h2000_0040, 0, 2'd0, 0, "R5");
    region(7, 32'h0000_0018, 32'h0000_0FE7, "R5");           // AP 11, attr 3, inside region 0
    acc(32'h0000_0800, 1, 2'd0, 0, "R5");

    // R9: attribute index retargeted; fault still carries attr
    acc(32'h2000_1040, 1, 2'd1, 0, "R9");
    region(2, 32'h2000_0000, 32'h2000_0FEB, "R9");           // attr 5
    acc(32'h2000_0040, 1, 2'd0, 0, "R9");

    // R6: background map
    acc(32'h9000_0000, 1, 2'd0, 0, "R6");
    wr(3'd0, 32'h5, "R6");
    acc(32'h9000_0000, 1, 2'd1, 0, "R6");
    acc(32'h9000_0000, 0, 2'd0, 0, "R6");
    acc(32'h0000_1000, 1, 2'd1, 0, "R6");

    // R3: handler context bypass
    acc(32'h9000_0000, 0, 2'd1, 1, "R3");
    acc(32'h4001_0100, 1, 2'd2, 1, "R3");
    wr(3'd0, 32'h7, "R3");
    acc(32'h9000_0000, 0, 2'd1, 1, "R3");
    acc(32'h4001_0100, 1, 2'd2, 1, "R3");

    // R11: write and access in the same cycle use the old configuration
    nAcc = 1; nAccAddr = 32'h9000_0000; nPriv = 0; nType = 2'd0; nHand = 0;
    wr(3'd0, 32'h0, "R11");
    acc(32'h9000_0000, 0, 2'd0, 0, "R11");
    wr(3'd0, 32'h1, "R11");
    nAcc = 1; nAccAddr = 32'h2000_0040; nPriv = 1; nType = 2'd0; nHand = 0;
    wr(3'd5, 32'h0000_0000, "R11");
    acc(32'h2000_0040, 1, 2'd0, 0, "R11");
    step("R11");
    step("R11");

    // R10: select read-back across windows
    for (int r = 0; r < 8; r++) begin
      wr(3'd1, 32'(r), "R10");
      rd(3'd2, "R10");
      rd(3'd3, "R10");
    end
    step("R11");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule